// File: doc/BRIEF.md
# Indirect Accumulator Load/Store Sequencer

This block sequences the accumulator's memory traffic for a small 8-bit core. A single start pulse, with an operation code, launches one of six operations. Four of them move a byte between the accumulator and memory. The address comes either from a selected register pair or from an already fetched 16-bit immediate address. The other two rotate nibbles through memory: the byte addressed by the HL pair is read, spliced with the accumulator's low nibble, and written back.

Every access keeps a hidden 16-bit transfer pointer up to date, the way real silicon does. The pointer is loaded with the effective address and the bus address is driven from it. The pointer then advances by one. A store also overwrites the pointer's upper byte with the stored data byte. The pointer value is brought out on its own port so that neighbouring logic, for example flag logic, can use it.

The memory side is a plain synchronous bus. Read data returns one clock after the read strobe. All outputs are registered.

Top module: `idx_mem_seq`

## Requirements
- R1: While reset is held and after it is released, `done`, `mem_rd`, `mem_wr`, `mem_addr`, `acc_o` and `tptr_o` are all zero.
- R2: The operation codes are 0 = load A via pair, 1 = store A via pair, 2 = load A via immediate, 3 = store A via immediate, 4 = rotate right through memory, 5 = rotate left through memory. The pair codes are `pair_sel` 0 = BC, 1 = DE, 2 or 3 = HL. A load via pair issues one read at the pair's value, returns the byte read on `acc_o`, and leaves `tptr_o` equal to that address plus one.
- R3: A store via pair issues one write of the accumulator byte at the pair's value. It leaves `tptr_o` holding the stored byte in bits 15:8 and the low byte of (address + 1) in bits 7:0. `acc_o` is unchanged from `acc_i`.
- R4: Codes 2 and 3 behave like codes 0 and 1 but take the address from `imm_addr`.
- R5: The pointer increment wraps: an access at 16'hFFFF leaves the low pointer byte at 8'h00, and a load there leaves `tptr_o` = 16'h0000.
- R6: Rotate right reads byte M at HL and writes back {A[3:0], M[7:4]} to HL. The result A becomes {A[7:4], M[3:0]} and `tptr_o` becomes HL + 1.
- R7: Rotate left reads byte M at HL and writes back {M[3:0], A[3:0]} to HL. The result A becomes {A[7:4], M[7:4]} and `tptr_o` becomes HL + 1.
- R8: `mem_rd`, `mem_wr` and `done` are each single-cycle pulses, and `mem_rd` and `mem_wr` are never high together. Each operation makes exactly its own accesses: one read for loads, one write for stores, and one read followed by one write for rotates.
- R9: Counting falling edges from the one where `start` is raised, `done` is first seen at count 2 for stores, 4 for loads and 6 for rotates. `done` for a store or rotate coincides with its `mem_wr` pulse, and a rotate leaves two idle cycles between capturing the read byte and writing back.
- R10: `start` is ignored while an operation is in progress, and it is ignored for codes 6 and 7. In both cases no extra access, `done` pulse or pointer change results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| op_code | input | 3 | Operation select (see R2) |
| pair_sel | input | 2 | Register pair select for codes 0 and 1 |
| pair_bc | input | 16 | BC pair value |
| pair_de | input | 16 | DE pair value |
| pair_hl | input | 16 | HL pair value |
| imm_addr | input | 16 | Fetched immediate address |
| acc_i | input | 8 | Accumulator value at launch |
| acc_o | output | 8 | Resulting accumulator, valid with done |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| tptr_o | output | 16 | Hidden transfer pointer value |

## Verification
A wrong pointer increment, a missing high-byte overwrite or a bad pointer load shows on `tptr_o` in the same cycle as `done`. A mis-sequenced state machine shows as a shifted `done` or a missing or extra strobe within a few cycles of launch. A wrong nibble splice corrupts both the write-back byte and `acc_o` at completion. Pointer wrap at the top of memory is driven directly, as are launches that should be ignored (codes 6 and 7, and a start raised mid-operation). These cases are mixed with seeded random operations over all pairs and codes.

// File: rtl/idxm_pkg.sv
package idxm_pkg;

  typedef enum logic [2:0] {
    OP_LD_PAIR = 3'd0,
    OP_ST_PAIR = 3'd1,
    OP_LD_IMM  = 3'd2,
    OP_ST_IMM  = 3'd3,
    OP_ROT_R   = 3'd4,
    OP_ROT_L   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_RWAIT,
    S_RCAP,
    S_GAP1,
    S_GAP2
  } st_e;

  function automatic logic op_ok(input logic [2:0] c);
    return c <= 3'd5;
  endfunction

  function automatic logic op_store(input op_e o);
    return (o == OP_ST_PAIR) || (o == OP_ST_IMM);
  endfunction

  function automatic logic op_rot(input op_e o);
    return (o == OP_ROT_R) || (o == OP_ROT_L);
  endfunction

endpackage

// File: rtl/idxm_ptr.sv
module idxm_ptr #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  input  logic          hi_wr,
  input  logic [DW-1:0] hi_val,
  output logic [AW-1:0] q
);
  localparam int LW = AW - DW;

  logic [AW-1:0] nxt_inc;
  logic [AW-1:0] nxt_hi;

  assign nxt_inc = q + AW'(1);

  generate
    if (LW > 0) begin : g_split
      assign nxt_hi = {hi_val, nxt_inc[LW-1:0]};
    end else begin : g_full
      assign nxt_hi = hi_val[AW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (inc)   q <= hi_wr ? nxt_hi : nxt_inc;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && !hi_wr && !load && q == '1) |=> (q == '0)); // R5

endmodule

// File: rtl/idxm_nib.sv
module idxm_nib #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mem,
  input  logic          left,
  output logic [DW-1:0] wr_byte,
  output logic [DW-1:0] acc_new
);
  localparam int NW = DW / 2;

  always_comb begin
    if (left) begin
      wr_byte = {mem[NW-1:0], acc[NW-1:0]};
      acc_new = {acc[DW-1:NW], mem[DW-1:NW]};
    end else begin
      wr_byte = {acc[NW-1:0], mem[DW-1:NW]};
      acc_new = {acc[DW-1:NW], mem[NW-1:0]};
    end
  end

endmodule

// File: rtl/idx_mem_seq.sv
module idx_mem_seq
  import idxm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op_code,
  input  logic [1:0]    pair_sel,
  input  logic [AW-1:0] pair_bc,
  input  logic [AW-1:0] pair_de,
  input  logic [AW-1:0] pair_hl,
  input  logic [AW-1:0] imm_addr,
  input  logic [DW-1:0] acc_i,
  output logic [DW-1:0] acc_o,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] tptr_o
);
  localparam int NW = DW / 2;

  st_e           st_q;
  op_e           op_q;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] mbuf_q;
  logic [AW-1:0] src;
  logic          launch;
  logic          is_st;
  logic          is_rot;
  logic [DW-1:0] spl_wr;
  logic [DW-1:0] spl_acc;

  assign launch = (st_q == S_IDLE) && start && op_ok(op_code);
  assign is_st  = op_store(op_q);
  assign is_rot = op_rot(op_q);

  always_comb begin
    case (op_code)
      3'd2, 3'd3: src = imm_addr;
      3'd4, 3'd5: src = pair_hl;
      default: begin
        case (pair_sel)
          2'd0:    src = pair_bc;
          2'd1:    src = pair_de;
          default: src = pair_hl;
        endcase
      end
    endcase
  end

  idxm_ptr #(.AW(AW), .DW(DW)) i_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (launch),
    .load_val (src),
    .inc      (st_q == S_ISSUE),
    .hi_wr    (is_st),
    .hi_val   (acc_q),
    .q        (tptr_o)
  );

  idxm_nib #(.DW(DW)) i_nib (
    .acc     (acc_q),
    .mem     (mbuf_q),
    .left    (op_q == OP_ROT_L),
    .wr_byte (spl_wr),
    .acc_new (spl_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      op_q      <= OP_LD_PAIR;
      acc_q     <= '0;
      mbuf_q    <= '0;
      acc_o     <= '0;
      done      <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      done   <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (launch) begin
            op_q  <= op_e'(op_code);
            acc_q <= acc_i;
            st_q  <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          mem_addr <= tptr_o;
          if (is_st) begin
            mem_wr    <= 1'b1;
            mem_wdata <= acc_q;
            acc_o     <= acc_q;
            done      <= 1'b1;
            st_q      <= S_IDLE;
          end else begin
            mem_rd <= 1'b1;
            st_q   <= S_RWAIT;
          end
        end
        S_RWAIT: st_q <= S_RCAP;
        S_RCAP: begin
          mbuf_q <= mem_rdata;
          if (is_rot) begin
            st_q <= S_GAP1;
          end else begin
            acc_o <= mem_rdata;
            done  <= 1'b1;
            st_q  <= S_IDLE;
          end
        end
        S_GAP1: st_q <= S_GAP2;
        S_GAP2: begin
          mem_wr    <= 1'b1;
          mem_wdata <= spl_wr;
          acc_o     <= spl_acc;
          done      <= 1'b1;
          st_q      <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R8
  AST_RD_PTR: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (tptr_o == mem_addr + AW'(1))); // R2
  AST_ST_HI: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !is_rot) |-> (tptr_o[AW-1 -: DW] == mem_wdata)); // R3
  AST_ROT_HI: assert property (@(posedge clk) disable iff (rst)
    (done && is_rot) |-> (acc_o[DW-1 -: NW] == acc_q[DW-1 -: NW])); // R6

endmodule

// File: tb/test_idx_mem_seq.sv
module test_idx_mem_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op_code = '0;
  logic [1:0]  pair_sel = '0;
  logic [15:0] pair_bc = '0, pair_de = '0, pair_hl = '0, imm_addr = '0;
  logic [7:0]  acc_i = '0;
  logic [7:0]  acc_o;
  logic        done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rd, mem_wr;
  logic [15:0] tptr_o;

  int n_chk = 0, n_bad = 0;
  int n_rd = 0, n_wr = 0, n_done = 0;
  logic [15:0] rd_a, wr_a;
  logic [7:0]  wr_d;
  logic        prev_done = 1'b0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_mem_seq i_idx_mem_seq (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code), .pair_sel(pair_sel),
    .pair_bc(pair_bc), .pair_de(pair_de), .pair_hl(pair_hl), .imm_addr(imm_addr),
    .acc_i(acc_i), .acc_o(acc_o), .done(done), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .tptr_o(tptr_o)
  );

  function automatic logic [7:0] mix(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mix(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd) begin n_rd++; rd_a = mem_addr; end
      if (mem_wr) begin n_wr++; wr_a = mem_addr; wr_d = mem_wdata; end
      if (done) n_done++;
      if (mem_rd && mem_wr) chk(1'b0, "R8 rd/wr overlap", 1, 0);
      if (done && prev_done) chk(1'b0, "R8 done width", 2, 1);
    end
    prev_done = done;
  end

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_up();
    end
  end

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [1:0] sel,
                        input logic [15:0] bc, input logic [15:0] de,
                        input logic [15:0] hl, input logic [15:0] imm,
                        input logic [7:0] a, input bit disturb, input string tag);
    logic [15:0] src, p1, exp_ptr;
    logic [7:0]  m, exp_acc, exp_wd;
    int exp_lat, exp_rd, exp_wr, lat;
    bit st, rot;
    st  = (op == 3'd1) || (op == 3'd3);
    rot = (op == 3'd4) || (op == 3'd5);
    if (op == 3'd2 || op == 3'd3) src = imm;
    else if (rot) src = hl;
    else src = (sel == 2'd0) ? bc : (sel == 2'd1) ? de : hl;
    p1 = src + 16'd1;
    m  = mix(src);
    exp_wd = a; exp_acc = a; exp_ptr = p1;
    if (st) begin exp_ptr = {a, p1[7:0]}; exp_lat = 2; exp_rd = 0; exp_wr = 1; end
    else if (rot) begin
      exp_lat = 6; exp_rd = 1; exp_wr = 1;
      if (op == 3'd4) begin exp_wd = {a[3:0], m[7:4]}; exp_acc = {a[7:4], m[3:0]}; end
      else begin exp_wd = {m[3:0], a[3:0]}; exp_acc = {a[7:4], m[7:4]}; end
    end else begin exp_acc = m; exp_lat = 4; exp_rd = 1; exp_wr = 0; end

    @(negedge clk);
    op_code = op; pair_sel = sel; pair_bc = bc; pair_de = de; pair_hl = hl;
    imm_addr = imm; acc_i = a; start = 1'b1;
    n_rd = 0; n_wr = 0; n_done = 0;
    lat = 0;
    while (lat < 12) begin
      @(negedge clk);
      lat++;
      if (lat == 1 && disturb) begin op_code = (op == 3'd0) ? 3'd1 : 3'd0; start = 1'b1; end
      else start = 1'b0;
      if (done) break;
    end
    chk(lat == exp_lat, "R9 latency", lat, exp_lat);
    chk(acc_o == exp_acc, {tag, " acc"}, acc_o, exp_acc);
    chk(tptr_o == exp_ptr, {tag, " pointer"}, tptr_o, exp_ptr);
    if (st || rot) chk(mem_wr == 1'b1, "R9 write with done", mem_wr, 1);
    repeat (3) @(negedge clk);
    chk(n_rd == exp_rd && n_wr == exp_wr && n_done == 1,
        disturb ? "R10 busy start" : "R8 access count",
        n_rd * 256 + n_wr * 16 + n_done, exp_rd * 256 + exp_wr * 16 + 1);
    chk(tptr_o == exp_ptr, disturb ? "R10 pointer held" : "R8 pointer held", tptr_o, exp_ptr);
    if (exp_rd == 1) chk(rd_a == src, {tag, " read addr"}, rd_a, src);
    if (exp_wr == 1) begin
      chk(wr_a == src, {tag, " write addr"}, wr_a, src);
      chk(wr_d == exp_wd, {tag, " write data"}, wr_d, exp_wd);
    end
  endtask

  initial begin
    logic [15:0] hold;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(done == 0 && mem_rd == 0 && mem_wr == 0, "R1 strobes in reset", {done, mem_rd, mem_wr}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(tptr_o == 0 && mem_addr == 0 && acc_o == 0, "R1 reset values",
        {tptr_o, mem_addr}, 0);

    run_op(3'd0, 2'd0, 16'h1234, 16'h4567, 16'h89AB, 16'h0, 8'h11, 0, "R2");
    run_op(3'd0, 2'd1, 16'h1234, 16'h4567, 16'h89AB, 16'h0, 8'h22, 0, "R2");
    run_op(3'd0, 2'd3, 16'h1234, 16'h4567, 16'h89AB, 16'h0, 8'h33, 0, "R2");
    run_op(3'd1, 2'd2, 16'h1234, 16'h4567, 16'h89FF, 16'h0, 8'hC7, 0, "R3");
    run_op(3'd1, 2'd0, 16'h10FE, 16'h4567, 16'h89AB, 16'h0, 8'h5E, 0, "R3");
    run_op(3'd2, 2'd0, 16'h0, 16'h0, 16'h0, 16'hBEEF, 8'h44, 0, "R4");
    run_op(3'd3, 2'd0, 16'h0, 16'h0, 16'h0, 16'h0100, 8'h99, 0, "R4");
    run_op(3'd2, 2'd0, 16'h0, 16'h0, 16'h0, 16'hFFFF, 8'h01, 0, "R5");
    run_op(3'd3, 2'd0, 16'h0, 16'h0, 16'h0, 16'hFFFF, 8'hA5, 0, "R5");
    run_op(3'd0, 2'd2, 16'h0, 16'h0, 16'hFFFF, 16'h0, 8'h02, 0, "R5");
    run_op(3'd4, 2'd0, 16'h0, 16'h0, 16'h2A5C, 16'h0, 8'hB6, 0, "R6");
    run_op(3'd5, 2'd0, 16'h0, 16'h0, 16'h2A5C, 16'h0, 8'hB6, 0, "R7");
    run_op(3'd4, 2'd0, 16'h0, 16'h0, 16'hFFFF, 16'h0, 8'h0F, 0, "R6");
    run_op(3'd5, 2'd1, 16'h0, 16'h0, 16'h0000, 16'h0, 8'hF0, 0, "R7");
    run_op(3'd1, 2'd1, 16'h0, 16'h7777, 16'h0, 16'h0, 8'h3D, 1, "R10");
    run_op(3'd4, 2'd0, 16'h0, 16'h0, 16'h1357, 16'h0, 8'h81, 1, "R10");

    hold = tptr_o;
    for (int c = 6; c <= 7; c++) begin
      @(negedge clk);
      op_code = 3'(c); start = 1'b1; n_rd = 0; n_wr = 0; n_done = 0;
      @(negedge clk); start = 1'b0;
      repeat (8) @(negedge clk);
      chk(n_rd == 0 && n_wr == 0 && n_done == 0 && tptr_o == hold,
          "R10 invalid code", tptr_o, hold);
    end

    for (int k = 0; k < 60; k++) begin
      logic [2:0] op;
      op = 3'($urandom % 6);
      run_op(op, 2'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
             16'($urandom), 8'($urandom), 0, tag_of(op));
    end

    finished = 1'b1;
    finish_up();
  end

endmodule